// File: doc/BRIEF.md
# Fractional-Correction Baud Rate Generator

This block derives the UART sampling clock from a selectable count clock. The count clock comes from one of three tick strobes: fast internal, slow internal or external. The fast source can be divided by a power of two, and an enable bit gates the count clock. A reload down-counter fires an underflow every `reload + 1` count-clock ticks, and the sampling clock toggles on each underflow.

A plain reload counter can only hit rates that are integer fractions of the count clock. To correct the rest, the block groups sixteen consecutive underflows into a correction window. A 4-bit fine setting `k` stretches exactly `k` of those sixteen periods by one count-clock tick. The stretched positions are picked by a bit-reversed spreading rule, so the extra ticks are spread evenly across the window and never bunch together. Software reaches two small registers through a one-bit register select: a clock-control register and a fine-setting register.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset both registers read 0x00, and `sclk_o` and `uf_o` are 0.
- R2: Register select 0 is clock control, with bit 7 = count enable, bits 5:4 = source code and bits 1:0 = divide code. Register select 1 is the fine setting in bits 3:0. All other bits read 0, and writes to them have no effect.
- R3: Source code 0 takes `fast_tick`, 1 takes `slow_tick` and 3 takes `ext_tick`. Code 2 is reserved and produces no count-clock ticks.
- R4: Divide code d divides the fast source by 2^d (1, 2, 4 or 8). With any other source the divide code is ignored and the ratio is 1.
- R5: While the enable is 0, no underflow occurs, `sclk_o` holds, and the window position returns to position 1. The first underflow after enabling is position 1.
- R6: An undelayed period lasts `reload + 1` count-clock ticks. Each underflow gives a one-cycle `uf_o` pulse and toggles `sclk_o`.
- R7: Sixteen consecutive underflows span 16 × (`reload` + 1) + k count-clock ticks, where k is the fine setting.
- R8: With setting k, the delayed positions are the first k entries of the order 16, 8, 12, 4, 14, 6, 10, 2, 15, 7, 11, 3, 13, 5, 9. Position 1 is never delayed, so setting 15 delays positions 2 to 16.
- R9: A delayed period is exactly one count-clock tick longer than an undelayed one, i.e. `reload + 2`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 clock control, 1 fine setting |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Read data of the selected register |
| reload | input | RELOAD_W | Reload value of the down-counter |
| fast_tick | input | 1 | Fast internal source strobe |
| slow_tick | input | 1 | Slow internal source strobe |
| ext_tick | input | 1 | External source strobe |
| uf_o | output | 1 | One-cycle pulse per underflow |
| sclk_o | output | 1 | Sampling clock, toggles on each underflow |

## Verification
The bench builds the block with its default 8-bit reload and 4-bit fine field. It drives small reload values of 3 and 0, so that each period is only a few cycles long. This makes it cheap to sweep all sixteen fine settings over two full windows each and to compare every single period, and every window total, against the position order. A reload of 0 exercises the stall path back-to-back with the reload, and strobes of period 2 and 3 cycles check the source and divider selection.

// File: rtl/fbr_pkg.sv
package fbr_pkg;

    localparam int FINE_W  = 4;
    localparam int DIV_W   = 2;
    localparam int SRC_W   = 2;
    localparam int REG_W   = 8;
    localparam int DCNT_W  = (1 << DIV_W) - 1;

    localparam int CTL_EN_BIT  = 7;
    localparam int CTL_SRC_LSB = 4;
    localparam int CTL_DIV_LSB = 0;

    typedef enum logic [SRC_W-1:0] {
        SRC_FAST = 2'd0,
        SRC_SLOW = 2'd1,
        SRC_NONE = 2'd2,
        SRC_EXT  = 2'd3
    } src_sel_e;

    typedef struct packed {
        logic                 en;
        src_sel_e             src;
        logic [DIV_W-1:0]     div;
    } clk_ctl_t;

    typedef logic [FINE_W-1:0] fine_t;

    function automatic fine_t bit_rev(input fine_t v);
        fine_t r;
        for (int i = 0; i < FINE_W; i++) begin
            r[i] = v[FINE_W-1-i];
        end
        return r;
    endfunction

    // slot holds (position - 1); (16 - position) mod 16 equals ~slot
    function automatic logic pos_delayed(input fine_t slot, input fine_t setting);
        return bit_rev(~slot) < setting;
    endfunction

endpackage

// File: rtl/fbr_regs.sv
module fbr_regs
    import fbr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              reg_sel,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    output clk_ctl_t          ctl,
    output fine_t             fine
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl  <= '{en: 1'b0, src: SRC_FAST, div: '0};
            fine <= '0;
        end else if (wr_en) begin
            if (!reg_sel) begin
                ctl.en  <= wr_data[CTL_EN_BIT];
                ctl.src <= src_sel_e'(wr_data[CTL_SRC_LSB +: SRC_W]);
                ctl.div <= wr_data[CTL_DIV_LSB +: DIV_W];
            end else begin
                fine <= wr_data[FINE_W-1:0];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (!reg_sel) begin
            rd_data[CTL_EN_BIT]                = ctl.en;
            rd_data[CTL_SRC_LSB +: SRC_W]      = ctl.src;
            rd_data[CTL_DIV_LSB +: DIV_W]      = ctl.div;
        end else begin
            rd_data[FINE_W-1:0] = fine;
        end
    end

endmodule

// File: rtl/fbr_clk_front.sv
module fbr_clk_front
    import fbr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  clk_ctl_t ctl,
    input  logic     fast_tick,
    input  logic     slow_tick,
    input  logic     ext_tick,
    output logic     cnt_tick
);

    logic              src_tick;
    logic [DCNT_W-1:0] div_cnt;
    logic [DCNT_W-1:0] ratio_m1;
    logic              div_hit;

    always_comb begin
        unique case (ctl.src)
            SRC_FAST: src_tick = fast_tick;
            SRC_SLOW: src_tick = slow_tick;
            SRC_EXT:  src_tick = ext_tick;
            default:  src_tick = 1'b0;
        endcase
    end

    // ratio minus one is a mask of div ones; only the fast source is divided
    always_comb begin
        ratio_m1 = '0;
        if (ctl.src == SRC_FAST) begin
            for (int i = 0; i < DCNT_W; i++) begin
                if (i < int'(ctl.div)) ratio_m1[i] = 1'b1;
            end
        end
    end

    assign div_hit  = (div_cnt >= ratio_m1);
    assign cnt_tick = ctl.en & src_tick & div_hit;

    always_ff @(posedge clk) begin
        if (rst || !ctl.en) begin
            div_cnt <= '0;
        end else if (src_tick) begin
            div_cnt <= div_hit ? '0 : div_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/fbr_reload_ctr.sv
module fbr_reload_ctr
    import fbr_pkg::*;
#(
    parameter int RELOAD_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic                cnt_tick,
    input  logic [RELOAD_W-1:0] reload,
    input  fine_t               fine,
    output logic                uf_o,
    output logic                sclk_o,
    output fine_t               slot_o,
    output logic                stall_o,
    output logic                cnt_zero_o
);

    logic [RELOAD_W-1:0] cnt_q;
    fine_t               slot_q;
    logic                stall_q;
    logic                delay_now;

    assign delay_now  = pos_delayed(slot_q, fine) && !stall_q;
    assign cnt_zero_o = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            slot_q  <= '0;
            stall_q <= 1'b0;
            uf_o    <= 1'b0;
            sclk_o  <= 1'b0;
        end else begin
            uf_o <= 1'b0;
            if (!en) begin
                slot_q  <= '0;
                stall_q <= 1'b0;
            end else if (cnt_tick) begin
                if (!cnt_zero_o) begin
                    cnt_q <= cnt_q - 1'b1;
                end else if (delay_now) begin
                    stall_q <= 1'b1;
                end else begin
                    cnt_q   <= reload;
                    stall_q <= 1'b0;
                    uf_o    <= 1'b1;
                    sclk_o  <= ~sclk_o;
                    slot_q  <= slot_q + 1'b1;
                end
            end
        end
    end

    assign slot_o  = slot_q;
    assign stall_o = stall_q;

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
    import fbr_pkg::*;
#(
    parameter int RELOAD_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic                reg_sel,
    input  logic [REG_W-1:0]    wr_data,
    output logic [REG_W-1:0]    rd_data,
    input  logic [RELOAD_W-1:0] reload,
    input  logic                fast_tick,
    input  logic                slow_tick,
    input  logic                ext_tick,
    output logic                uf_o,
    output logic                sclk_o
);

    clk_ctl_t ctl;
    fine_t    fine;
    logic     cnt_tick;
    fine_t    slot;
    logic     stall;
    logic     cnt_zero;

    fbr_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .reg_sel (reg_sel),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .ctl     (ctl),
        .fine    (fine)
    );

    fbr_clk_front u_front (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .fast_tick (fast_tick),
        .slow_tick (slow_tick),
        .ext_tick  (ext_tick),
        .cnt_tick  (cnt_tick)
    );

    fbr_reload_ctr #(.RELOAD_W(RELOAD_W)) u_ctr (
        .clk        (clk),
        .rst        (rst),
        .en         (ctl.en),
        .cnt_tick   (cnt_tick),
        .reload     (reload),
        .fine       (fine),
        .uf_o       (uf_o),
        .sclk_o     (sclk_o),
        .slot_o     (slot),
        .stall_o    (stall),
        .cnt_zero_o (cnt_zero)
    );

endmodule

// File: rtl/fbr_checker.sv
module fbr_checker
    import fbr_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        en,
    input logic [1:0]  src,
    input fine_t       fine,
    input logic        cnt_tick,
    input fine_t       slot,
    input logic        stall,
    input logic        cnt_zero,
    input logic        uf,
    input logic        sclk
);

    AST_RSV_SRC_SILENT: assert property (@(posedge clk) disable iff (rst)
        (src == 2'd2) |-> !cnt_tick); // R3

    AST_DIS_NO_UF: assert property (@(posedge clk) disable iff (rst)
        !en |=> !uf); // R5

    AST_DIS_SLOT_HOME: assert property (@(posedge clk) disable iff (rst)
        !en |=> (slot == '0)); // R5

    AST_SCLK_FLIP: assert property (@(posedge clk) disable iff (rst)
        uf |-> (sclk != $past(sclk))); // R6

    AST_FIRST_POS_PLAIN: assert property (@(posedge clk) disable iff (rst)
        stall |-> (slot != '0)); // R8

    AST_MAX_ALL_DELAY: assert property (@(posedge clk) disable iff (rst)
        (en && cnt_tick && cnt_zero && !stall && fine == 4'hF && slot != '0) |=> stall); // R8

    AST_STALL_ONE_TICK: assert property (@(posedge clk) disable iff (rst)
        (en && cnt_tick && stall) |=> uf); // R9

endmodule

bind frac_baud_gen fbr_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (ctl.en),
    .src      (ctl.src),
    .fine     (fine),
    .cnt_tick (cnt_tick),
    .slot     (slot),
    .stall    (stall),
    .cnt_zero (cnt_zero),
    .uf       (uf_o),
    .sclk     (sclk_o)
);

// File: tb/frac_baud_gen_bench.sv
`timescale 1ns/1ps
module frac_baud_gen_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       reg_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [7:0] reload = 8'd3;
    logic       fast_tick = 1'b1;
    logic       slow_tick = 1'b0;
    logic       ext_tick = 1'b0;
    logic       uf_o;
    logic       sclk_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    int phase    = 0;

    always #2.5 clk = ~clk;

    frac_baud_gen u_frac_baud_gen (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .reg_sel   (reg_sel),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .reload    (reload),
        .fast_tick (fast_tick),
        .slow_tick (slow_tick),
        .ext_tick  (ext_tick),
        .uf_o      (uf_o),
        .sclk_o    (sclk_o)
    );

    // slow strobe every 3 cycles, external strobe every 2 cycles
    always @(negedge clk) begin
        phase     = phase + 1;
        slow_tick = (phase % 3 == 0);
        ext_tick  = (phase % 2 == 0);
    end

    int order [15] = '{16, 8, 12, 4, 14, 6, 10, 2, 15, 7, 11, 3, 13, 5, 9};

    function automatic bit exp_delayed(input int pos, input int k);
        for (int i = 0; i < k; i++) if (order[i] == pos) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [7:0] ctl_byte(input bit en, input int src, input int dv);
        return {en, 1'b0, 2'(src), 2'b00, 2'(dv)};
    endfunction

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic write_reg(input bit sel, input logic [7:0] d);
        @(negedge clk);
        reg_sel = sel; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_reg(input bit sel, output logic [7:0] d);
        @(negedge clk);
        reg_sel = sel;
        #1;
        d = rd_data;
    endtask

    // cycles until the next sampled uf pulse; -1 on timeout
    task automatic next_uf(input int limit, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!uf_o && n < limit);
        if (!uf_o) n = -1;
    endtask

    task automatic sweep(input int k, input int rl);
        int n, sum, pos, exp_len;
        logic last_sclk;
        write_reg(1'b0, ctl_byte(1'b0, 0, 0));
        reload = 8'(rl);
        write_reg(1'b1, 8'(k));
        write_reg(1'b0, ctl_byte(1'b1, 0, 0));
        next_uf(1000, n);
        check(n > 0, "R5", "first underflow after enable", n, 1);
        last_sclk = sclk_o;
        sum = 0;
        for (int j = 0; j < 32; j++) begin
            next_uf(1000, n);
            pos = ((j + 1) % 16) + 1;
            exp_len = rl + 1 + (exp_delayed(pos, k) ? 1 : 0);
            if (exp_delayed(pos, k))
                check(n == exp_len, "R9", $sformatf("k=%0d delayed pos %0d", k, pos), n, exp_len);
            else
                check(n == exp_len, "R8", $sformatf("k=%0d plain pos %0d", k, pos), n, exp_len);
            check(sclk_o != last_sclk, "R6", "sclk toggle", int'(sclk_o), int'(!last_sclk));
            last_sclk = sclk_o;
            sum += n;
            if (j % 16 == 15) begin
                check(sum == 16 * (rl + 1) + k, "R7", $sformatf("k=%0d window length", k),
                      sum, 16 * (rl + 1) + k);
                sum = 0;
            end
        end
    endtask

    task automatic steady_period(input int src, input int dv, input int exp, input string req);
        int n;
        write_reg(1'b0, ctl_byte(1'b0, 0, 0));
        reload = 8'd3;
        write_reg(1'b1, 8'h00);
        write_reg(1'b0, ctl_byte(1'b1, src, dv));
        next_uf(1000, n);
        for (int j = 0; j < 3; j++) begin
            next_uf(1000, n);
            check(n == exp, req, $sformatf("src=%0d div=%0d period", src, dv), n, exp);
        end
    endtask

    initial begin
        logic [7:0] d;
        int cnt_uf;
        logic s0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        read_reg(1'b0, d); check(d == 8'h00, "R1", "ctl after reset", d, 0);
        read_reg(1'b1, d); check(d == 8'h00, "R1", "fine after reset", d, 0);
        check(sclk_o == 1'b0, "R1", "sclk after reset", sclk_o, 0);
        check(uf_o == 1'b0, "R1", "uf after reset", uf_o, 0);

        // R2 field layout and reserved bits
        write_reg(1'b1, 8'hFF);
        read_reg(1'b1, d); check(d == 8'h0F, "R2", "fine readback", d, 8'h0F);
        write_reg(1'b0, 8'h4A);
        read_reg(1'b0, d); check(d == 8'h02, "R2", "ctl reserved bits", d, 8'h02);
        write_reg(1'b0, 8'hB3);
        read_reg(1'b0, d); check(d == 8'hB3, "R2", "ctl full fields", d, 8'hB3);

        // R5 disabled: no underflow, sclk holds
        write_reg(1'b0, ctl_byte(1'b0, 0, 0));
        s0 = sclk_o; cnt_uf = 0;
        repeat (100) begin @(negedge clk); if (uf_o) cnt_uf++; end
        check(cnt_uf == 0, "R5", "underflows while disabled", cnt_uf, 0);
        check(sclk_o == s0, "R5", "sclk while disabled", sclk_o, s0);

        // R3 reserved source gives no ticks
        write_reg(1'b0, ctl_byte(1'b1, 2, 0));
        cnt_uf = 0;
        repeat (100) begin @(negedge clk); if (uf_o) cnt_uf++; end
        check(cnt_uf == 0, "R3", "underflows on reserved source", cnt_uf, 0);

        // R3/R4 sources and divider, reload 3
        steady_period(0, 0, 4,  "R6");
        steady_period(0, 1, 8,  "R4");
        steady_period(0, 2, 16, "R4");
        steady_period(0, 3, 32, "R4");
        steady_period(1, 3, 12, "R3");
        steady_period(3, 1, 8,  "R3");

        // R7/R8/R9 sweep of all fine settings
        for (int k = 0; k < 16; k++) sweep(k, 3);
        sweep(5, 0);
        sweep(15, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule